// File: doc/BRIEF.md
# CAN Timestamp Timer Controller

This block keeps a free-running timestamp count for a CAN controller and snapshots it when mailbox events happen. The count advances by one on each prescaled tick. It can be restarted from a programmable reload value in two ways: by a match against a compare register, or by a received message whose mailbox has its ID-compare flag set.

Two capture registers hold copies of the count. One takes a copy on a transmit event. A control bit selects whether that event is the setting of the transmit request or the transmit acknowledge. The other takes a copy on a receive-stored strobe. A received ID-compare event can turn the receive capture off automatically, which freezes the last value it captured.

A compare match sets a sticky interrupt flag, and the host clears it by writing 1 to it. Mailbox logic supplies single-cycle strobes. The host reaches all state through a small word-wide register port. Writes take effect at the clock edge, and reads are combinational on the address.

Top module: `can_tstamp_timer`

## Requirements
- R1: After reset the count, the reload, compare and capture registers, the control register and the interrupt flag are all zero, and `irq` is low.
- R2: The count advances by one on each clock edge where `tick` is high and no reload occurs. Otherwise it holds.
- R3: On a tick with no reload, the count goes from all-ones to zero.
- R4: A compare hit is a tick while the count equals the compare register (address 2). On a hit with control bit 1 set, the count takes the reload value (address 1) instead of advancing. With bit 1 clear, a hit does not alter the count.
- R5: A compare hit sets the interrupt flag whatever the state of control bit 1. The flag is read at address 6 bit 0 and drives `irq`. Writing 1 to bit 0 of address 6 clears it, and writing 0 leaves it set. A hit in the same cycle as a clearing write leaves the flag set.
- R6: With control bit 2 set, `rxStored` together with `rxIdMatch` loads the reload value into the count. That load takes priority over a tick in the same cycle, and it never sets the interrupt flag.
- R7: With control bit 0 clear, `txReqSet` copies the count into the transmit capture register (address 3) and `txAck` has no effect. With bit 0 set, `txAck` makes the copy and `txReqSet` has no effect.
- R8: `rxStored` copies the count into the receive capture register (address 4) only while control bit 4 is set.
- R9: With control bit 3 set, `rxStored` together with `rxIdMatch` clears control bit 4 in hardware. The receive capture register keeps its previous value on that cycle.
- R10: Control register bits above bit 4 always read as 0, whatever value is written to them. The count can be read at address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` |
| tick | input | 1 | Prescaled count enable |
| txReqSet | input | 1 | Strobe: a transmit request was set |
| txAck | input | 1 | Strobe: a transmission was acknowledged |
| rxStored | input | 1 | Strobe: a mailbox stored a received message |
| rxIdMatch | input | 1 | ID-compare flag of that mailbox, valid with `rxStored` |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The reload path is tried with several compare and reload pairs, with compare reload switched on and off:
- A compare above the reached count shows plain counting.
- A compare of zero shows a hit on the very first tick.
- A reload equal to the compare shows a count that stays on that value.

The enable-off case separates "hit flagged" from "hit reloads". Each capture strobe is also sent while it should be ignored, so that a capture wired to the wrong event is caught. The same-cycle orderings are driven on purpose: a tick with an ID reload, and a hit with a flag clear.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int CTRL_BITS = 5;
  localparam int B_TX_ON_ACK = 0;
  localparam int B_CMP_RELOAD = 1;
  localparam int B_ID_RELOAD = 2;
  localparam int B_AUTO_DIS = 3;
  localparam int B_RX_EN = 4;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_RELOAD = 3'd1;
  localparam logic [2:0] A_COMPARE = 3'd2;
  localparam logic [2:0] A_TXCAP = 3'd3;
  localparam logic [2:0] A_RXCAP = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;
  localparam logic [2:0] A_IRQ = 3'd6;

  typedef struct packed {
    logic load;
    logic step;
    logic capTx;
    logic capRx;
  } dpStrobe_t;
endpackage

// File: rtl/tstamp_datapath.sv
module tstamp_datapath
  import tstamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] txCap,
  output logic [CNT_W-1:0] rxCap
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      txCap <= '0;
      rxCap <= '0;
    end else begin
      if (stb.load) count <= reloadVal;
      else if (stb.step) count <= count + 1'b1;
      if (stb.capTx) txCap <= count;
      if (stb.capRx) rxCap <= count;
    end
  end

  p_reload_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> count == $past(reloadVal));
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && count == ALL_ONES) |=> count == '0);
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capRx |=> $stable(rxCap));
endmodule

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  input  logic             tick,
  input  logic             txReqSet,
  input  logic             txAck,
  input  logic             rxStored,
  input  logic             rxIdMatch,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] txCap,
  input  logic [CNT_W-1:0] rxCap,
  output dpStrobe_t        stb,
  output logic [CNT_W-1:0] reloadVal,
  output logic             irqFlag
);
  localparam int PAD_W = CNT_W - CTRL_BITS;

  logic [CTRL_BITS-1:0] ctrlReg;
  logic [CNT_W-1:0] compareReg;
  logic idEvent, cmpHit, autoDis, irqClear;

  assign idEvent = rxStored && rxIdMatch;
  assign cmpHit = tick && (count == compareReg);
  assign autoDis = idEvent && ctrlReg[B_AUTO_DIS];
  assign irqClear = regWe && (regAddr == A_IRQ) && regWdata[0];

  always_comb begin
    stb.load = (cmpHit && ctrlReg[B_CMP_RELOAD]) || (idEvent && ctrlReg[B_ID_RELOAD]);
    stb.step = tick && !stb.load;
    stb.capTx = ctrlReg[B_TX_ON_ACK] ? txAck : txReqSet;
    stb.capRx = rxStored && ctrlReg[B_RX_EN] && !autoDis;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      reloadVal <= '0;
      compareReg <= '0;
      irqFlag <= 1'b0;
    end else begin
      if (regWe && regAddr == A_CTRL) ctrlReg <= regWdata[CTRL_BITS-1:0];
      if (autoDis) ctrlReg[B_RX_EN] <= 1'b0;
      if (regWe && regAddr == A_RELOAD) reloadVal <= regWdata;
      if (regWe && regAddr == A_COMPARE) compareReg <= regWdata;
      if (cmpHit) irqFlag <= 1'b1;
      else if (irqClear) irqFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      A_CTRL:    regRdata = {{PAD_W{1'b0}}, ctrlReg};
      A_RELOAD:  regRdata = reloadVal;
      A_COMPARE: regRdata = compareReg;
      A_TXCAP:   regRdata = txCap;
      A_RXCAP:   regRdata = rxCap;
      A_COUNT:   regRdata = count;
      A_IRQ:     regRdata = {{(CNT_W-1){1'b0}}, irqFlag};
      default:   regRdata = '0;
    endcase
  end

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClear) |=> irqFlag);
  p_id_no_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idEvent && !cmpHit && !irqFlag) |=> !irqFlag);
  p_auto_dis_r9: assert property (@(posedge clk) disable iff (!rstN)
    autoDis |=> !ctrlReg[B_RX_EN]);
  p_hit_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmpHit |=> irqFlag);
endmodule

// File: rtl/can_tstamp_timer.sv
module can_tstamp_timer
  import tstamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  input  logic             tick,
  input  logic             txReqSet,
  input  logic             txAck,
  input  logic             rxStored,
  input  logic             rxIdMatch,
  output logic             irq
);
  dpStrobe_t stb;
  logic [CNT_W-1:0] count, txCap, rxCap, reloadVal;

  tstamp_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tick(tick),
    .txReqSet(txReqSet), .txAck(txAck), .rxStored(rxStored),
    .rxIdMatch(rxIdMatch), .count(count), .txCap(txCap), .rxCap(rxCap),
    .stb(stb), .reloadVal(reloadVal), .irqFlag(irq)
  );

  tstamp_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reloadVal(reloadVal),
    .count(count), .txCap(txCap), .rxCap(rxCap)
  );
endmodule

// File: tb/can_tstamp_timer_test.sv
module can_tstamp_timer_test;
  logic clk = 1'b0;
  logic rstN, regWe, tick, txReqSet, txAck, rxStored, rxIdMatch, irq;
  logic [2:0] regAddr;
  logic [15:0] regWdata, regRdata;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_tstamp_timer uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tick(tick),
    .txReqSet(txReqSet), .txAck(txAck), .rxStored(rxStored),
    .rxIdMatch(rxIdMatch), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] reloadV;
    logic [15:0] compareV;
    logic [4:0]  ctrlV;
    logic [7:0]  ticks;
    logic [15:0] expCount;
    logic        expIrq;
  } vec_t;

  localparam vec_t VECS[5] = '{
    '{16'h0000, 16'h0100, 5'h00, 8'd5, 16'h0005, 1'b0},
    '{16'h0010, 16'h0003, 5'h02, 8'd6, 16'h0012, 1'b1},
    '{16'h0010, 16'h0003, 5'h00, 8'd6, 16'h0006, 1'b1},
    '{16'h0020, 16'h0000, 5'h02, 8'd1, 16'h0020, 1'b1},
    '{16'h0002, 16'h0002, 5'h02, 8'd4, 16'h0002, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; tick = 1'b0;
    txReqSet = 1'b0; txAck = 1'b0; rxStored = 1'b0; rxIdMatch = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic pulse(input logic t, input logic rq, input logic ak,
                       input logic rs, input logic im);
    tick = t; txReqSet = rq; txAck = ak; rxStored = rs; rxIdMatch = im;
    @(negedge clk);
    tick = 1'b0; txReqSet = 1'b0; txAck = 1'b0; rxStored = 1'b0; rxIdMatch = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    rstN = 1'b0;

    // R1: reset state
    doReset();
    rd(3'd5, v); chk("R1 count", v, 16'h0);
    rd(3'd3, v); chk("R1 txCap", v, 16'h0);
    rd(3'd4, v); chk("R1 rxCap", v, 16'h0);
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R2 R4 R5: vector table
    foreach (VECS[k]) begin
      doReset();
      wr(3'd1, VECS[k].reloadV);
      wr(3'd2, VECS[k].compareV);
      wr(3'd0, {11'h0, VECS[k].ctrlV});
      ticks(int'(VECS[k].ticks));
      rd(3'd5, v); chk($sformatf("R2/R4 vec%0d count", k), v, VECS[k].expCount);
      chk($sformatf("R5 vec%0d irq", k), {15'h0, irq}, {15'h0, VECS[k].expIrq});
    end

    // R6, R3: ID reload then wrap
    doReset();
    wr(3'd2, 16'h0100);
    wr(3'd1, 16'hFFFE);
    wr(3'd0, 16'h0004);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    rd(3'd5, v); chk("R6 id reload", v, 16'hFFFE);
    chk("R6 no irq", {15'h0, irq}, 16'h0);
    ticks(1);
    rd(3'd5, v); chk("R2 step", v, 16'hFFFF);
    ticks(1);
    rd(3'd5, v); chk("R3 wrap", v, 16'h0000);
    pulse(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    rd(3'd5, v); chk("R6 reload beats tick", v, 16'hFFFE);

    // R5: clear behaviour
    doReset();
    wr(3'd2, 16'h0002);
    ticks(3);
    chk("R5 flag set", {15'h0, irq}, 16'h1);
    wr(3'd6, 16'h0000);
    chk("R5 write0 keeps", {15'h0, irq}, 16'h1);
    wr(3'd6, 16'h0001);
    chk("R5 write1 clears", {15'h0, irq}, 16'h0);
    wr(3'd2, 16'h0003);
    tick = 1'b1;
    wr(3'd6, 16'h0001);
    tick = 1'b0;
    chk("R5 hit beats clear", {15'h0, irq}, 16'h1);

    // R7: transmit capture select
    doReset();
    wr(3'd2, 16'h0100);
    ticks(4);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rd(3'd3, v); chk("R7 ack ignored", v, 16'h0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(3'd3, v); chk("R7 req capture", v, 16'h4);
    ticks(2);
    wr(3'd0, 16'h0001);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(3'd3, v); chk("R7 req ignored", v, 16'h4);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rd(3'd3, v); chk("R7 ack capture", v, 16'h6);

    // R8 R9: receive capture and auto-disable
    doReset();
    wr(3'd2, 16'h0100);
    ticks(3);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd(3'd4, v); chk("R8 disabled", v, 16'h0);
    wr(3'd0, 16'h0010);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd(3'd4, v); chk("R8 capture", v, 16'h3);
    ticks(1);
    wr(3'd0, 16'h0018);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    rd(3'd4, v); chk("R9 rxCap frozen", v, 16'h3);
    rd(3'd0, v); chk("R9 enable cleared", v, 16'h0008);
    rd(3'd5, v); chk("R6 no reload when off", v, 16'h4);

    // R10: reserved bits
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); chk("R10 reserved", v, 16'h001F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule